// File: doc/BRIEF.md
# Masked Bus-Match Comparator

This block watches a 16-bit processor bus and raises a one-clock match pulse when an access hits a programmed address. In forced mode it can also require the data on the bus to agree with a programmed value. That data comparison works bit by bit under an 8-bit mask for each byte lane. A match can be narrowed further to reads only or writes only. It can also be narrowed to byte accesses only or word accesses only.

In tagged mode the data bus is not compared. A qualifying access only marks the address as tagged. The match pulse is raised later, when an execute strobe reports that the tagged address has actually executed. With each pulse comes a flag that tells a forced match from a tagged one. A downstream sequencer or breakpoint unit uses the pulse and the flag.

The configuration registers sit in bank 0 of an indexed byte-wide register port. They can be read only in that bank. They can be written only in that bank and only while the arm input is low.

Top module: `dbg_bus_cmp`

Register indices (bank 0): 0 control, 1 address high byte, 2 address low byte, 3 data high byte (bus bits 15:8), 4 data low byte (bus bits 7:0), 5 mask high byte, 6 mask low byte. Control bits: bit0 enable, bit1 tag mode, bit2 direction check on, bit3 direction wanted (1 = read), bit4 size check on, bit5 size wanted (1 = byte).

## Requirements
- R1: After reset every register index 0 to 6 reads 0x00, and `match` and `match_tagged` are 0.
- R2: With `reg_bank` = 0, `reg_rdata` shows the register selected by `reg_idx` one clock after the index is presented. With any other bank value, `reg_rdata` is 0x00.
- R3: A write takes effect only when `reg_bank` = 0 and `arm` = 0. A write under any other bank value, or while `arm` = 1, leaves all registers unchanged.
- R4: In forced mode (tag bit 0), with the enable bit set and `arm` = 1, a bus access whose address equals the programmed address sets `match` = 1 and `match_tagged` = 0 exactly one clock later. An access to any other address gives `match` = 0.
- R5: In forced mode, data bit i must equal compare bit i wherever mask bit i is 1. Where mask bit i is 0, data bit i does not matter.
- R6: On a byte access (`bus_byte` = 1), only one lane is compared. An even address compares bits 15:8, an odd address compares bits 7:0, and the other lane is treated as fully masked.
- R7: When the direction check is on, only accesses whose `bus_rd` equals the wanted direction can match.
- R8: When the size check is on, only accesses whose `bus_byte` equals the wanted size can match.
- R9: In tagged mode the data is not compared. A qualifying access arms a tag. An `exec_valid` on the programmed address while the tag is held gives `match` = 1 with `match_tagged` = 1 one clock later, and this clears the tag. An execute strobe with no tag held gives no match.
- R10: While `arm` = 0 no match is produced, and dropping `arm` discards any held tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Debug armed: enables matching and locks writes |
| reg_we | input | 1 | Register write strobe |
| reg_bank | input | 2 | Bank-select field; registers live in bank 0 |
| reg_idx | input | 3 | Register index within the bank |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_addr | input | 16 | Bus address |
| bus_data | input | 16 | Bus data |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| exec_valid | input | 1 | Execute strobe for a previously fetched address |
| exec_addr | input | 16 | Address being executed |
| match | output | 1 | One-clock match pulse |
| match_tagged | output | 1 | With match: 1 = tagged, 0 = forced |

## Verification
Every result of this block is due exactly one clock after its stimulus. A forced match follows the bus access, a tagged match follows the execute strobe, and read data follows the index. A write is visible on a read presented on the next cycle. The bench drives inputs on the falling edge, holds them across one rising edge and samples at the following falling edge. Each check therefore lands on the one cycle in which the registered output reflects that stimulus. Between accesses the bench deasserts the strobe, so every pulse is seen as its own single cycle.

// File: rtl/dbg_cmp_pkg.sv
package dbg_cmp_pkg;
  localparam int REG_W   = 8;
  localparam int NREG    = 7;
  localparam int IDX_W   = 3;
  localparam logic [IDX_W-1:0] IDX_CTRL   = 3'd0;
  localparam logic [IDX_W-1:0] IDX_ADDR_H = 3'd1;
  localparam logic [IDX_W-1:0] IDX_ADDR_L = 3'd2;
  localparam logic [IDX_W-1:0] IDX_DATA_H = 3'd3;
  localparam logic [IDX_W-1:0] IDX_DATA_L = 3'd4;
  localparam logic [IDX_W-1:0] IDX_MASK_H = 3'd5;
  localparam logic [IDX_W-1:0] IDX_MASK_L = 3'd6;

  typedef struct packed {
    logic [1:0] spare;
    logic       size_byte;
    logic       size_chk;
    logic       dir_read;
    logic       dir_chk;
    logic       tag_mode;
    logic       enable;
  } cmp_ctrl_t;
endpackage

// File: rtl/dbg_cmp_regs.sv
module dbg_cmp_regs
  import dbg_cmp_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             we,
  input  logic [1:0]       bank,
  input  logic [IDX_W-1:0] idx,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output cmp_ctrl_t        ctrl,
  output logic [AW-1:0]    cmp_addr,
  output logic [DW-1:0]    cmp_data,
  output logic [DW-1:0]    cmp_mask
);
  logic [REG_W-1:0] regs [NREG];
  logic             bank_ok;
  logic             wr_ok;

  assign bank_ok = (bank == 2'b00);
  assign wr_ok   = we && bank_ok && !arm;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      rdata <= '0;
    end else begin
      if (wr_ok && (int'(idx) < NREG)) regs[idx] <= wdata;
      if (bank_ok && (int'(idx) < NREG)) rdata <= regs[idx];
      else                               rdata <= '0;
    end
  end

  assign ctrl     = cmp_ctrl_t'(regs[IDX_CTRL]);
  assign cmp_addr = AW'({regs[IDX_ADDR_H], regs[IDX_ADDR_L]});
  assign cmp_data = DW'({regs[IDX_DATA_H], regs[IDX_DATA_L]});
  assign cmp_mask = DW'({regs[IDX_MASK_H], regs[IDX_MASK_L]});

  AST_WRITE_LOCK: assert property (@(posedge clk) disable iff (rst)
    (we && arm) |=> ($stable(cmp_addr) && $stable(cmp_data) && $stable(cmp_mask)
                     && $stable(ctrl))) else $error("write while armed");  // R3
  AST_BANK_READ: assert property (@(posedge clk) disable iff (rst)
    (bank != 2'b00) |=> (rdata == '0)) else $error("read outside bank");  // R2
endmodule

// File: rtl/dbg_cmp_match.sv
module dbg_cmp_match
  import dbg_cmp_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  cmp_ctrl_t     ctrl,
  input  logic [AW-1:0] cmp_addr,
  input  logic [DW-1:0] cmp_data,
  input  logic [DW-1:0] cmp_mask,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_rd,
  input  logic          bus_byte,
  output logic          hit
);
  localparam int NLANE = DW / REG_W;

  logic [DW-1:0] eff_mask;
  logic          addr_hit, data_hit, dir_ok, size_ok;

  // Byte lanes: highest lane sits at the even address; a byte access
  // selects one lane by the low address bit, word access uses all lanes.
  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic lane_on;
    assign lane_on = !bus_byte ||
                     (bus_addr[0] == ((NLANE - 1 - l) % 2 == 1));
    assign eff_mask[l*REG_W +: REG_W] = lane_on ? cmp_mask[l*REG_W +: REG_W] : '0;
  end

  assign addr_hit = (bus_addr == cmp_addr);
  assign data_hit = (((bus_data ^ cmp_data) & eff_mask) == '0);
  assign dir_ok   = !ctrl.dir_chk  || (bus_rd   == ctrl.dir_read);
  assign size_ok  = !ctrl.size_chk || (bus_byte == ctrl.size_byte);
  assign hit      = bus_valid && ctrl.enable && addr_hit && dir_ok && size_ok &&
                    (ctrl.tag_mode || data_hit);
endmodule

// File: rtl/dbg_cmp_tag.sv
module dbg_cmp_tag #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          tag_mode,
  input  logic          hit,
  input  logic          exec_valid,
  input  logic [AW-1:0] exec_addr,
  input  logic [AW-1:0] cmp_addr,
  output logic          fire
);
  logic pending;

  assign fire = arm && tag_mode && pending && exec_valid && (exec_addr == cmp_addr);

  always_ff @(posedge clk) begin
    if (rst || !arm || !tag_mode) pending <= 1'b0;
    else if (fire)                pending <= 1'b0;
    else if (hit)                 pending <= 1'b1;
  end

  AST_TAG_DROPS_ON_DISARM: assert property (@(posedge clk) disable iff (rst)
    !arm |=> !pending) else $error("tag kept while disarmed");  // R10
endmodule

// File: rtl/dbg_bus_cmp.sv
module dbg_bus_cmp
  import dbg_cmp_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             reg_we,
  input  logic [1:0]       reg_bank,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             bus_valid,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_data,
  input  logic             bus_rd,
  input  logic             bus_byte,
  input  logic             exec_valid,
  input  logic [AW-1:0]    exec_addr,
  output logic             match,
  output logic             match_tagged
);
  cmp_ctrl_t     ctrl;
  logic [AW-1:0] cmp_addr;
  logic [DW-1:0] cmp_data, cmp_mask;
  logic          hit, tag_fire, forced_fire;

  dbg_cmp_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .arm(arm), .we(reg_we), .bank(reg_bank),
    .idx(reg_idx), .wdata(reg_wdata), .rdata(reg_rdata), .ctrl(ctrl),
    .cmp_addr(cmp_addr), .cmp_data(cmp_data), .cmp_mask(cmp_mask)
  );

  dbg_cmp_match #(.AW(AW), .DW(DW)) u_match (
    .ctrl(ctrl), .cmp_addr(cmp_addr), .cmp_data(cmp_data), .cmp_mask(cmp_mask),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_rd(bus_rd), .bus_byte(bus_byte), .hit(hit)
  );

  dbg_cmp_tag #(.AW(AW)) u_tag (
    .clk(clk), .rst(rst), .arm(arm), .tag_mode(ctrl.tag_mode), .hit(hit),
    .exec_valid(exec_valid), .exec_addr(exec_addr), .cmp_addr(cmp_addr),
    .fire(tag_fire)
  );

  assign forced_fire = arm && !ctrl.tag_mode && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      match        <= 1'b0;
      match_tagged <= 1'b0;
    end else begin
      match        <= forced_fire || tag_fire;
      match_tagged <= tag_fire;
    end
  end

  AST_MATCH_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    match |-> $past(arm)) else $error("match while disarmed");  // R10
  AST_FORCED_ADDR: assert property (@(posedge clk) disable iff (rst)
    (match && !match_tagged) |-> ($past(bus_valid) && $past(bus_addr) == $past(cmp_addr)))
    else $error("forced match without address hit");  // R4
  AST_TAGGED_EXEC: assert property (@(posedge clk) disable iff (rst)
    (match && match_tagged) |-> ($past(exec_valid) && $past(exec_addr) == $past(cmp_addr)))
    else $error("tagged match without execute");  // R9
  AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (rst)
    match_tagged |-> match) else $error("flag without pulse");  // R9
endmodule

// File: tb/dbg_bus_cmp_tb.sv
module dbg_bus_cmp_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        arm = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_bank = 2'b00;
  logic [2:0]  reg_idx = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        bus_valid = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_data = '0;
  logic        bus_rd = 1'b0;
  logic        bus_byte = 1'b0;
  logic        exec_valid = 1'b0;
  logic [15:0] exec_addr = '0;
  logic        match, match_tagged;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  dbg_bus_cmp u_dut (
    .clk(clk), .rst(rst), .arm(arm), .reg_we(reg_we), .reg_bank(reg_bank),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_rd(bus_rd), .bus_byte(bus_byte), .exec_valid(exec_valid),
    .exec_addr(exec_addr), .match(match), .match_tagged(match_tagged)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [7:0] val, input logic [1:0] bank = 2'b00);
    reg_we = 1'b1; reg_idx = idx; reg_wdata = val; reg_bank = bank;
    @(negedge clk);
    reg_we = 1'b0; reg_bank = 2'b00;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [7:0] val, input logic [1:0] bank = 2'b00);
    reg_idx = idx; reg_bank = bank;
    @(negedge clk);
    val = reg_rdata;
    reg_bank = 2'b00;
  endtask

  task automatic access(input logic [15:0] a, input logic [15:0] d, input logic r,
                        input logic b, output logic m, output logic t);
    bus_valid = 1'b1; bus_addr = a; bus_data = d; bus_rd = r; bus_byte = b;
    @(negedge clk);
    m = match; t = match_tagged;
    bus_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic execute(input logic [15:0] a, output logic m, output logic t);
    exec_valid = 1'b1; exec_addr = a;
    @(negedge clk);
    m = match; t = match_tagged;
    exec_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] ctl, input logic [15:0] a,
                       input logic [15:0] d, input logic [15:0] msk);
    arm = 1'b0;
    @(negedge clk);
    wr(3'd0, ctl); wr(3'd1, a[15:8]); wr(3'd2, a[7:0]);
    wr(3'd3, d[15:8]); wr(3'd4, d[7:0]); wr(3'd5, msk[15:8]); wr(3'd6, msk[7:0]);
    arm = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int i = 0; i < 7; i++) begin
      rd(3'(i), v);
      check("R1 reg reset", {8'h0, v}, 16'h0000);
    end
    check("R1 match reset", {15'h0, match}, 16'h0);
    check("R1 tagged reset", {15'h0, match_tagged}, 16'h0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(3'd1, 8'h5A);
    rd(3'd1, v);  check("R2 readback", {8'h0, v}, 16'h005A);
    rd(3'd1, v, 2'b01); check("R2 other bank reads zero", {8'h0, v}, 16'h0000);
    wr(3'd1, 8'h77, 2'b10);
    rd(3'd1, v);  check("R3 write in other bank ignored", {8'h0, v}, 16'h005A);
    arm = 1'b1;
    wr(3'd1, 8'h33);
    arm = 1'b0;
    rd(3'd1, v);  check("R3 write while armed ignored", {8'h0, v}, 16'h005A);
  endtask

  task automatic t_forced();
    logic m, t;
    setup(8'h01, 16'h1234, 16'h0000, 16'h0000);
    access(16'h1234, 16'hFFFF, 1'b1, 1'b0, m, t);
    check("R4 address hit", {14'h0, m, t}, 16'h0002);
    access(16'h1235, 16'h0000, 1'b1, 1'b0, m, t);
    check("R4 address miss", {15'h0, m}, 16'h0);
    arm = 1'b0;
    @(negedge clk);
    access(16'h1234, 16'h0000, 1'b1, 1'b0, m, t);
    check("R10 disarmed no match", {15'h0, m}, 16'h0);
    setup(8'h00, 16'h1234, 16'h0000, 16'h0000);
    access(16'h1234, 16'h0000, 1'b1, 1'b0, m, t);
    check("R4 disabled no match", {15'h0, m}, 16'h0);
  endtask

  task automatic t_mask();
    logic m, t;
    setup(8'h01, 16'h1234, 16'hABC5, 16'hFF0F);
    access(16'h1234, 16'hAB35, 1'b0, 1'b0, m, t);
    check("R5 masked bits ignored", {15'h0, m}, 16'h1);
    access(16'h1234, 16'hAC05, 1'b0, 1'b0, m, t);
    check("R5 high lane mismatch", {15'h0, m}, 16'h0);
    access(16'h1234, 16'hABC6, 1'b0, 1'b0, m, t);
    check("R5 low nibble mismatch", {15'h0, m}, 16'h0);
  endtask

  task automatic t_byte();
    logic m, t;
    setup(8'h01, 16'h1234, 16'hABC5, 16'hFFFF);
    access(16'h1234, 16'hAB00, 1'b0, 1'b1, m, t);
    check("R6 even byte uses high lane", {15'h0, m}, 16'h1);
    access(16'h1234, 16'h00C5, 1'b0, 1'b1, m, t);
    check("R6 even byte high lane mismatch", {15'h0, m}, 16'h0);
    access(16'h1234, 16'hAB00, 1'b0, 1'b0, m, t);
    check("R6 word compares both lanes", {15'h0, m}, 16'h0);
    setup(8'h01, 16'h1235, 16'hABC5, 16'hFFFF);
    access(16'h1235, 16'h00C5, 1'b0, 1'b1, m, t);
    check("R6 odd byte uses low lane", {15'h0, m}, 16'h1);
    access(16'h1235, 16'hABC4, 1'b0, 1'b1, m, t);
    check("R6 odd byte low lane mismatch", {15'h0, m}, 16'h0);
  endtask

  task automatic t_qual();
    logic m, t;
    setup(8'h0D, 16'h2000, 16'h0000, 16'h0000);
    access(16'h2000, 16'h0, 1'b1, 1'b0, m, t);
    check("R7 read wanted, read", {15'h0, m}, 16'h1);
    access(16'h2000, 16'h0, 1'b0, 1'b0, m, t);
    check("R7 read wanted, write", {15'h0, m}, 16'h0);
    setup(8'h11, 16'h2000, 16'h0000, 16'h0000);
    access(16'h2000, 16'h0, 1'b0, 1'b0, m, t);
    check("R8 word wanted, word", {15'h0, m}, 16'h1);
    access(16'h2000, 16'h0, 1'b0, 1'b1, m, t);
    check("R8 word wanted, byte", {15'h0, m}, 16'h0);
  endtask

  task automatic t_tag();
    logic m, t;
    setup(8'h03, 16'h4321, 16'h1111, 16'hFFFF);
    execute(16'h4321, m, t);
    check("R9 execute with no tag", {15'h0, m}, 16'h0);
    access(16'h4321, 16'h9999, 1'b1, 1'b0, m, t);
    check("R9 access alone no pulse", {15'h0, m}, 16'h0);
    execute(16'h4320, m, t);
    check("R9 execute other address", {15'h0, m}, 16'h0);
    execute(16'h4321, m, t);
    check("R9 tagged pulse, data ignored", {14'h0, m, t}, 16'h0003);
    execute(16'h4321, m, t);
    check("R9 tag cleared after fire", {15'h0, m}, 16'h0);
    access(16'h4321, 16'h0, 1'b1, 1'b0, m, t);
    arm = 1'b0;
    @(negedge clk);
    arm = 1'b1;
    @(negedge clk);
    execute(16'h4321, m, t);
    check("R10 disarm drops tag", {15'h0, m}, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_forced();
    t_mask();
    t_byte();
    t_qual();
    t_tag();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule